// File: doc/BRIEF.md
# Device-Memory Single-Access AXI Translator

This block sits between a processor load/store unit and a 32-bit AXI3 peripheral port. It turns one load or store aimed at Device or Strongly Ordered memory into exactly one AXI read-address or write-address request. The request keeps the width the instruction asked for and is never widened or split. For stores, the block places the data on the correct byte lanes and drives the matching write strobes. For loads, it moves the returned lanes down to bit 0 and clears the bytes above the access width.

An access that is not aligned to its own size does not reach the bus. The block accepts it and reports it back as an alignment fault one cycle later. Only one transaction is in flight at a time. The request side stays blocked from acceptance until the write response, or the final read beat, has been taken. The result then comes back as a single-cycle response pulse that carries the read data and the AXI response code.

Top module: `dev_access_bridge`

## Requirements
- R1: The request size code selects the AXI size. Code 0 (byte) gives AxSIZE 0, code 1 (halfword) gives AxSIZE 1, code 2 (word) gives AxSIZE 2, and code 3 (doubleword-style single access) is issued as a 32-bit transfer with AxSIZE 2 and needs word alignment.
- R2: Every AR and AW request is an incrementing burst (AxBURST 2'b01) of one beat (AxLEN 0) with AxPROT 3'b010, which marks a non-secure, unprivileged data access.
- R3: AWADDR and ARADDR equal the request address unchanged.
- R4: A byte store drives WSTRB with only bit N set, where N is address bits [1:0] (0001, 0010, 0100 or 1000).
- R5: A halfword store drives WSTRB 0011 at offset 0 and 1100 at offset 2, and a word store drives 1111. WDATA is the store data shifted left by 8 times address bits [1:0].
- R6: A halfword request with address bit 0 set, or a word or doubleword request with address bits [1:0] non-zero, is accepted and issues no AXI request. In the next cycle it gives rsp_valid with rsp_fault=1, rsp_resp=0, and req_ready is high again.
- R7: AWID, WID and ARID equal req_virt: 0 for the normal port and 1 for the virtual port.
- R8: WVALID rises only after the AW handshake of the same transaction, and WLAST is high on that beat.
- R9: req_ready is high out of reset and low from acceptance until the response. rsp_valid is a one-cycle pulse in the cycle after the B handshake, or after the R handshake with RLAST, and req_ready is high again in that cycle.
- R10: Read data returns in rsp_rdata shifted right by 8 times address bits [1:0], with bytes beyond the access width forced to 0. rsp_resp carries RRESP or BRESP.
- R11: AWVALID and ARVALID, once raised, stay high with their address and size stable until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU access request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword-as-word |
| req_write | input | 1 | 1 store, 0 load |
| req_wdata | input | 32 | Store data, right-justified |
| req_virt | input | 1 | Port select used as the AXI ID |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Load data, right-justified and zero-extended |
| rsp_resp | output | 2 | AXI response code of the transaction |
| rsp_fault | output | 1 | Alignment fault, no bus access made |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | ADDR_W | Write address |
| m_awid | output | ID_W | Write ID |
| m_awlen | output | 4 | Burst length minus one |
| m_awsize | output | 3 | Beat size |
| m_awburst | output | 2 | Burst type |
| m_awprot | output | 3 | Protection attributes |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | 32 | Write data on the bus lanes |
| m_wstrb | output | 4 | Byte strobes |
| m_wlast | output | 1 | Last beat of the burst |
| m_wid | output | ID_W | Write data ID |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response code |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | ADDR_W | Read address |
| m_arid | output | ID_W | Read ID |
| m_arlen | output | 4 | Burst length minus one |
| m_arsize | output | 3 | Beat size |
| m_arburst | output | 2 | Burst type |
| m_arprot | output | 3 | Protection attributes |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_rdata | input | 32 | Read data |
| m_rresp | input | 2 | Read response code |
| m_rlast | input | 1 | Last read beat |

## Verification
The bench stores a byte at every lane offset and halfwords at both legal offsets, then checks each strobe and data placement. A lane off by one would leave the wrong byte enabled at the slave. It issues misaligned halfword, word and doubleword accesses and checks that neither address channel moves. A design that forwarded these would reach the slave with a misaligned address. Loads at non-zero offsets check the down-shift and the zero fill, which would go wrong if the lanes were passed straight through. A held-off AW, a non-final read beat, and a W channel watched for early assertion check that ordering and the single-outstanding rule hold when the slave is slow.

// File: rtl/devb_pkg.sv
package devb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_AW,
      ST_W,
      ST_B,
      ST_AR,
      ST_R
   } devb_state_e;

   localparam logic [1:0] SZ_BYTE  = 2'd0;
   localparam logic [1:0] SZ_HALF  = 2'd1;
   localparam logic [1:0] SZ_WORD  = 2'd2;

   localparam logic [1:0] BURST_INCR   = 2'b01;
   localparam logic [2:0] PROT_NS_DATA = 3'b010;
   localparam logic [3:0] LEN_ONE_BEAT = 4'd0;

   // number of bytes a request size code moves on the bus
   function automatic int size_bytes(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: return 1;
         SZ_HALF: return 2;
         default: return 4;
      endcase
   endfunction

endpackage

// File: rtl/devb_lane_decode.sv
module devb_lane_decode
   import devb_pkg::*;
#(
   parameter int LANES = 4,
   localparam int OFF_W = $clog2(LANES)
) (
   input  logic [OFF_W-1:0] off,
   input  logic [1:0]       size,
   output logic             fault,
   output logic [LANES-1:0] strb,
   output logic [2:0]       axsize
);

   int nb;
   int offs;

   always_comb begin
      nb   = size_bytes(size);
      offs = int'(off);
      case (size)
         SZ_BYTE: axsize = 3'd0;
         SZ_HALF: axsize = 3'd1;
         default: axsize = 3'd2;
      endcase
      fault = ((offs % nb) != 0);
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign strb[g] = (g >= offs) && (g < offs + nb);
   end

endmodule

// File: rtl/devb_rd_align.sv
module devb_rd_align
   import devb_pkg::*;
#(
   parameter int LANES = 4,
   localparam int OFF_W = $clog2(LANES),
   localparam int DW = 8 * LANES
) (
   input  logic [OFF_W-1:0] off,
   input  logic [1:0]       size,
   input  logic [DW-1:0]    bus_data,
   output logic [DW-1:0]    cpu_data
);

   logic [DW-1:0] shifted;
   int nb;

   always_comb begin
      shifted = bus_data >> {off, 3'b000};
      nb      = size_bytes(size);
   end

   for (genvar j = 0; j < LANES; j++) begin : g_keep
      assign cpu_data[8*j +: 8] = (j < nb) ? shifted[8*j +: 8] : 8'h00;
   end

endmodule

// File: rtl/devb_ctrl.sv
module devb_ctrl
   import devb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int ID_W   = 1,
   parameter int LANES  = 4,
   localparam int OFF_W = $clog2(LANES),
   localparam int DW    = 8 * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic              req_write,
   input  logic [DW-1:0]     req_wdata,
   input  logic              req_virt,
   input  logic              dec_fault,
   input  logic [LANES-1:0]  dec_strb,
   input  logic [2:0]        dec_axsize,
   output logic [ADDR_W-1:0] q_addr,
   output logic [1:0]        q_size,
   output logic [2:0]        q_axsize,
   output logic [LANES-1:0]  q_strb,
   output logic [DW-1:0]     q_wdata,
   output logic [ID_W-1:0]   q_id,
   output logic              awvalid,
   input  logic              awready,
   output logic              wvalid,
   input  logic              wready,
   input  logic              bvalid,
   output logic              bready,
   input  logic [1:0]        bresp,
   output logic              arvalid,
   input  logic              arready,
   input  logic              rvalid,
   output logic              rready,
   input  logic [1:0]        rresp,
   input  logic              rlast,
   input  logic [DW-1:0]     rd_aligned,
   output logic              rsp_valid,
   output logic [DW-1:0]     rsp_rdata,
   output logic [1:0]        rsp_resp,
   output logic              rsp_fault
);

   devb_state_e state;

   always_comb begin
      req_ready = (state == ST_IDLE);
      awvalid   = (state == ST_AW);
      wvalid    = (state == ST_W);
      bready    = (state == ST_B);
      arvalid   = (state == ST_AR);
      rready    = (state == ST_R);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         q_addr    <= '0;
         q_size    <= '0;
         q_axsize  <= '0;
         q_strb    <= '0;
         q_wdata   <= '0;
         q_id      <= '0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         rsp_resp  <= '0;
         rsp_fault <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  if (dec_fault) begin
                     rsp_valid <= 1'b1;
                     rsp_fault <= 1'b1;
                     rsp_resp  <= 2'b00;
                     rsp_rdata <= '0;
                  end else begin
                     q_addr   <= req_addr;
                     q_size   <= req_size;
                     q_axsize <= dec_axsize;
                     q_strb   <= dec_strb;
                     q_wdata  <= req_wdata << {req_addr[OFF_W-1:0], 3'b000};
                     q_id     <= ID_W'(req_virt);
                     state    <= req_write ? ST_AW : ST_AR;
                  end
               end
            end
            ST_AW: if (awready) state <= ST_W;
            ST_W:  if (wready)  state <= ST_B;
            ST_B: begin
               if (bvalid) begin
                  rsp_valid <= 1'b1;
                  rsp_fault <= 1'b0;
                  rsp_resp  <= bresp;
                  rsp_rdata <= '0;
                  state     <= ST_IDLE;
               end
            end
            ST_AR: if (arready) state <= ST_R;
            ST_R: begin
               if (rvalid && rlast) begin
                  rsp_valid <= 1'b1;
                  rsp_fault <= 1'b0;
                  rsp_resp  <= rresp;
                  rsp_rdata <= rd_aligned;
                  state     <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dev_access_bridge.sv
module dev_access_bridge
   import devb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int ID_W   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_virt,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [1:0]        rsp_resp,
   output logic              rsp_fault,
   output logic              m_awvalid,
   input  logic              m_awready,
   output logic [ADDR_W-1:0] m_awaddr,
   output logic [ID_W-1:0]   m_awid,
   output logic [3:0]        m_awlen,
   output logic [2:0]        m_awsize,
   output logic [1:0]        m_awburst,
   output logic [2:0]        m_awprot,
   output logic              m_wvalid,
   input  logic              m_wready,
   output logic [DATA_W-1:0] m_wdata,
   output logic [DATA_W/8-1:0] m_wstrb,
   output logic              m_wlast,
   output logic [ID_W-1:0]   m_wid,
   input  logic              m_bvalid,
   output logic              m_bready,
   input  logic [1:0]        m_bresp,
   output logic              m_arvalid,
   input  logic              m_arready,
   output logic [ADDR_W-1:0] m_araddr,
   output logic [ID_W-1:0]   m_arid,
   output logic [3:0]        m_arlen,
   output logic [2:0]        m_arsize,
   output logic [1:0]        m_arburst,
   output logic [2:0]        m_arprot,
   input  logic              m_rvalid,
   output logic              m_rready,
   input  logic [DATA_W-1:0] m_rdata,
   input  logic [1:0]        m_rresp,
   input  logic              m_rlast
);

   localparam int LANES = DATA_W / 8;
   localparam int OFF_W = $clog2(LANES);

   if (DATA_W != 32) begin : g_bad_width
      $error("dev_access_bridge: DATA_W must be 32");
   end
   if (ID_W < 1) begin : g_bad_id
      $error("dev_access_bridge: ID_W must be at least 1");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("dev_access_bridge: ADDR_W too small");
   end

   logic              dec_fault;
   logic [LANES-1:0]  dec_strb;
   logic [2:0]        dec_axsize;
   logic [ADDR_W-1:0] q_addr;
   logic [1:0]        q_size;
   logic [2:0]        q_axsize;
   logic [LANES-1:0]  q_strb;
   logic [DATA_W-1:0] q_wdata;
   logic [ID_W-1:0]   q_id;
   logic [DATA_W-1:0] rd_aligned;

   devb_lane_decode #(.LANES(LANES)) u_decode (
      .off    (req_addr[OFF_W-1:0]),
      .size   (req_size),
      .fault  (dec_fault),
      .strb   (dec_strb),
      .axsize (dec_axsize)
   );

   devb_ctrl #(.ADDR_W(ADDR_W), .ID_W(ID_W), .LANES(LANES)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_addr   (req_addr),
      .req_size   (req_size),
      .req_write  (req_write),
      .req_wdata  (req_wdata),
      .req_virt   (req_virt),
      .dec_fault  (dec_fault),
      .dec_strb   (dec_strb),
      .dec_axsize (dec_axsize),
      .q_addr     (q_addr),
      .q_size     (q_size),
      .q_axsize   (q_axsize),
      .q_strb     (q_strb),
      .q_wdata    (q_wdata),
      .q_id       (q_id),
      .awvalid    (m_awvalid),
      .awready    (m_awready),
      .wvalid     (m_wvalid),
      .wready     (m_wready),
      .bvalid     (m_bvalid),
      .bready     (m_bready),
      .bresp      (m_bresp),
      .arvalid    (m_arvalid),
      .arready    (m_arready),
      .rvalid     (m_rvalid),
      .rready     (m_rready),
      .rresp      (m_rresp),
      .rlast      (m_rlast),
      .rd_aligned (rd_aligned),
      .rsp_valid  (rsp_valid),
      .rsp_rdata  (rsp_rdata),
      .rsp_resp   (rsp_resp),
      .rsp_fault  (rsp_fault)
   );

   devb_rd_align #(.LANES(LANES)) u_rd_align (
      .off      (q_addr[OFF_W-1:0]),
      .size     (q_size),
      .bus_data (m_rdata),
      .cpu_data (rd_aligned)
   );

   assign m_awaddr  = q_addr;
   assign m_awid    = q_id;
   assign m_awlen   = LEN_ONE_BEAT;
   assign m_awsize  = q_axsize;
   assign m_awburst = BURST_INCR;
   assign m_awprot  = PROT_NS_DATA;
   assign m_wdata   = q_wdata;
   assign m_wstrb   = q_strb;
   assign m_wlast   = m_wvalid;
   assign m_wid     = q_id;
   assign m_araddr  = q_addr;
   assign m_arid    = q_id;
   assign m_arlen   = LEN_ONE_BEAT;
   assign m_arsize  = q_axsize;
   assign m_arburst = BURST_INCR;
   assign m_arprot  = PROT_NS_DATA;

endmodule

// File: rtl/devb_chk.sv
module devb_chk #(
   parameter int ADDR_W = 32,
   parameter int LANES  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              awvalid,
   input logic              awready,
   input logic [ADDR_W-1:0] awaddr,
   input logic [2:0]        awsize,
   input logic [3:0]        awlen,
   input logic [1:0]        awburst,
   input logic              wvalid,
   input logic              wready,
   input logic [LANES-1:0]  wstrb,
   input logic              wlast,
   input logic              bvalid,
   input logic              bready,
   input logic              arvalid,
   input logic              arready,
   input logic [ADDR_W-1:0] araddr,
   input logic [2:0]        arsize,
   input logic [3:0]        arlen,
   input logic [1:0]        arburst,
   input logic              rready,
   input logic              rsp_valid
);

   logic       aw_seen;
   logic [2:0] aw_sz;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aw_seen <= 1'b0;
         aw_sz   <= 3'd0;
      end else if (awvalid && awready) begin
         aw_seen <= 1'b1;
         aw_sz   <= awsize;
      end else if (wvalid && wready) begin
         aw_seen <= 1'b0;
      end
   end

   // R11
   aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awsize));

   // R11
   ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arvalid && !arready |=> arvalid && $stable(araddr) && $stable(arsize));

   // R8
   w_after_aw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wvalid |-> aw_seen);

   // R8
   wlast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wvalid |-> wlast);

   // R2
   aw_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      awvalid |-> (awlen == 4'd0) && (awburst == 2'b01));

   // R2
   ar_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arvalid |-> (arlen == 4'd0) && (arburst == 2'b01));

   // R5
   strb_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wvalid |-> ($countones(wstrb) == (32'd1 << aw_sz)));

   // R9
   one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (awvalid || wvalid || bready || arvalid || rready) |-> !req_ready);

   // R9
   b_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bvalid && bready |=> rsp_valid && req_ready);

endmodule

bind dev_access_bridge devb_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .awvalid   (m_awvalid),
   .awready   (m_awready),
   .awaddr    (m_awaddr),
   .awsize    (m_awsize),
   .awlen     (m_awlen),
   .awburst   (m_awburst),
   .wvalid    (m_wvalid),
   .wready    (m_wready),
   .wstrb     (m_wstrb),
   .wlast     (m_wlast),
   .bvalid    (m_bvalid),
   .bready    (m_bready),
   .arvalid   (m_arvalid),
   .arready   (m_arready),
   .araddr    (m_araddr),
   .arsize    (m_arsize),
   .arlen     (m_arlen),
   .arburst   (m_arburst),
   .rready    (m_rready),
   .rsp_valid (rsp_valid)
);

// File: tb/test_dev_access_bridge.sv
`timescale 1ns/1ps
module test_dev_access_bridge;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        req_virt = 1'b0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic [1:0]  rsp_resp;
   logic        rsp_fault;
   logic        m_awvalid, m_awready = 1'b0;
   logic [31:0] m_awaddr;
   logic [0:0]  m_awid;
   logic [3:0]  m_awlen;
   logic [2:0]  m_awsize;
   logic [1:0]  m_awburst;
   logic [2:0]  m_awprot;
   logic        m_wvalid, m_wready = 1'b0;
   logic [31:0] m_wdata;
   logic [3:0]  m_wstrb;
   logic        m_wlast;
   logic [0:0]  m_wid;
   logic        m_bvalid = 1'b0, m_bready;
   logic [1:0]  m_bresp = '0;
   logic        m_arvalid, m_arready = 1'b0;
   logic [31:0] m_araddr;
   logic [0:0]  m_arid;
   logic [3:0]  m_arlen;
   logic [2:0]  m_arsize;
   logic [1:0]  m_arburst;
   logic [2:0]  m_arprot;
   logic        m_rvalid = 1'b0, m_rready;
   logic [31:0] m_rdata = '0;
   logic [1:0]  m_rresp = '0;
   logic        m_rlast = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dev_access_bridge i_dev_access_bridge (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
      .req_virt(req_virt),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_resp(rsp_resp),
      .rsp_fault(rsp_fault),
      .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
      .m_awid(m_awid), .m_awlen(m_awlen), .m_awsize(m_awsize),
      .m_awburst(m_awburst), .m_awprot(m_awprot),
      .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata),
      .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_wid(m_wid),
      .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp),
      .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
      .m_arid(m_arid), .m_arlen(m_arlen), .m_arsize(m_arsize),
      .m_arburst(m_arburst), .m_arprot(m_arprot),
      .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata),
      .m_rresp(m_rresp), .m_rlast(m_rlast)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive_req(input logic [31:0] a, input logic [1:0] s, input logic wr,
                            input logic [31:0] d, input logic v);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_size = s;
      req_write = wr; req_wdata = d; req_virt = v;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 reset req_ready", 32'(req_ready), 32'd1);
      chk("R9 reset awvalid", 32'(m_awvalid), 32'd0);
      chk("R9 reset arvalid", 32'(m_arvalid), 32'd0);
      chk("R9 reset rsp_valid", 32'(rsp_valid), 32'd0);
   endtask

   task automatic t_write(input logic [31:0] a, input logic [1:0] s, input logic [31:0] d,
                          input logic v, input logic [2:0] exp_sz, input logic [3:0] exp_strb,
                          input logic [31:0] exp_wdata, input logic [1:0] resp, input bit stall);
      drive_req(a, s, 1'b1, d, v);
      chk("R3 awaddr", m_awaddr, a);
      chk("R1 awsize", 32'(m_awsize), 32'(exp_sz));
      chk("R2 awlen", 32'(m_awlen), 32'd0);
      chk("R2 awburst", 32'(m_awburst), 32'd1);
      chk("R2 awprot", 32'(m_awprot), 32'd2);
      chk("R7 awid", 32'(m_awid), 32'(v));
      chk("R8 no early wvalid", 32'(m_wvalid), 32'd0);
      chk("R9 busy req_ready", 32'(req_ready), 32'd0);
      if (stall) begin
         @(negedge clk);
         chk("R11 awvalid held", 32'(m_awvalid), 32'd1);
         chk("R11 awaddr held", m_awaddr, a);
         chk("R8 wvalid waits for AW", 32'(m_wvalid), 32'd0);
      end
      m_awready = 1'b1;
      @(negedge clk);
      m_awready = 1'b0;
      chk("R11 awvalid dropped", 32'(m_awvalid), 32'd0);
      chk("R8 wvalid", 32'(m_wvalid), 32'd1);
      chk("R8 wlast", 32'(m_wlast), 32'd1);
      chk("R4 R5 wstrb", 32'(m_wstrb), 32'(exp_strb));
      chk("R5 wdata", m_wdata, exp_wdata);
      chk("R7 wid", 32'(m_wid), 32'(v));
      m_wready = 1'b1;
      @(negedge clk);
      m_wready = 1'b0;
      chk("R9 bready", 32'(m_bready), 32'd1);
      chk("R9 rsp not early", 32'(rsp_valid), 32'd0);
      m_bvalid = 1'b1; m_bresp = resp;
      @(negedge clk);
      m_bvalid = 1'b0;
      chk("R9 rsp_valid after B", 32'(rsp_valid), 32'd1);
      chk("R10 bresp", 32'(rsp_resp), 32'(resp));
      chk("R6 no fault", 32'(rsp_fault), 32'd0);
      chk("R9 ready again", 32'(req_ready), 32'd1);
      @(negedge clk);
      chk("R9 rsp pulse", 32'(rsp_valid), 32'd0);
   endtask

   task automatic t_read(input logic [31:0] a, input logic [1:0] s, input logic v,
                         input logic [31:0] bus, input logic [1:0] resp,
                         input logic [2:0] exp_sz, input logic [31:0] exp_data, input bit extra);
      drive_req(a, s, 1'b0, 32'h0, v);
      chk("R3 araddr", m_araddr, a);
      chk("R1 arsize", 32'(m_arsize), 32'(exp_sz));
      chk("R2 arlen", 32'(m_arlen), 32'd0);
      chk("R2 arburst", 32'(m_arburst), 32'd1);
      chk("R2 arprot", 32'(m_arprot), 32'd2);
      chk("R7 arid", 32'(m_arid), 32'(v));
      chk("R9 no aw on read", 32'(m_awvalid), 32'd0);
      m_arready = 1'b1;
      @(negedge clk);
      m_arready = 1'b0;
      chk("R9 rready", 32'(m_rready), 32'd1);
      if (extra) begin
         m_rvalid = 1'b1; m_rlast = 1'b0; m_rdata = 32'hDEADBEEF; m_rresp = 2'b00;
         @(negedge clk);
         chk("R9 no rsp before rlast", 32'(rsp_valid), 32'd0);
         chk("R9 still busy", 32'(req_ready), 32'd0);
      end
      m_rvalid = 1'b1; m_rlast = 1'b1; m_rdata = bus; m_rresp = resp;
      @(negedge clk);
      m_rvalid = 1'b0; m_rlast = 1'b0;
      chk("R9 rsp_valid after R", 32'(rsp_valid), 32'd1);
      chk("R10 rdata", rsp_rdata, exp_data);
      chk("R10 rresp", 32'(rsp_resp), 32'(resp));
      chk("R6 no fault", 32'(rsp_fault), 32'd0);
      chk("R9 ready again", 32'(req_ready), 32'd1);
      @(negedge clk);
      chk("R9 rsp pulse", 32'(rsp_valid), 32'd0);
   endtask

   task automatic t_fault(input logic [31:0] a, input logic [1:0] s, input logic wr);
      drive_req(a, s, wr, 32'hFFFF_FFFF, 1'b0);
      chk("R6 fault rsp_valid", 32'(rsp_valid), 32'd1);
      chk("R6 fault flag", 32'(rsp_fault), 32'd1);
      chk("R6 fault resp", 32'(rsp_resp), 32'd0);
      chk("R6 no awvalid", 32'(m_awvalid), 32'd0);
      chk("R6 no arvalid", 32'(m_arvalid), 32'd0);
      chk("R6 ready", 32'(req_ready), 32'd1);
      @(negedge clk);
      chk("R6 still no awvalid", 32'(m_awvalid), 32'd0);
      chk("R6 still no arvalid", 32'(m_arvalid), 32'd0);
      chk("R6 no wvalid", 32'(m_wvalid), 32'd0);
   endtask

   task automatic t_byte_writes();
      for (int o = 0; o < 4; o++) begin
         t_write(32'h4000_1000 + 32'(o), 2'd0, 32'h0000_005A, o[0], 3'd0,
                 4'(1 << o), 32'h5A << (8 * o), 2'b00, 1'b0);
      end
   endtask

   task automatic t_half_word_writes();
      t_write(32'h4000_2000, 2'd1, 32'h0000_1234, 1'b0, 3'd1, 4'b0011, 32'h0000_1234, 2'b00, 1'b1);
      t_write(32'h4000_2002, 2'd1, 32'h0000_1234, 1'b1, 3'd1, 4'b1100, 32'h1234_0000, 2'b11, 1'b0);
      t_write(32'h4000_2004, 2'd2, 32'hCAFE_F00D, 1'b0, 3'd2, 4'b1111, 32'hCAFE_F00D, 2'b00, 1'b0);
      // R1 doubleword-style request is issued as a 32-bit word
      t_write(32'h4000_2008, 2'd3, 32'h0BAD_C0DE, 1'b1, 3'd2, 4'b1111, 32'h0BAD_C0DE, 2'b10, 1'b0);
   endtask

   task automatic t_reads();
      t_read(32'h4000_3002, 2'd0, 1'b0, 32'hA1B2_C3D4, 2'b00, 3'd0, 32'h0000_00B2, 1'b0);
      t_read(32'h4000_3001, 2'd0, 1'b1, 32'hA1B2_C3D4, 2'b00, 3'd0, 32'h0000_00C3, 1'b0);
      t_read(32'h4000_3002, 2'd1, 1'b0, 32'hA1B2_C3D4, 2'b00, 3'd1, 32'h0000_A1B2, 1'b0);
      t_read(32'h4000_3000, 2'd1, 1'b0, 32'hA1B2_C3D4, 2'b01, 3'd1, 32'h0000_C3D4, 1'b0);
      t_read(32'h4000_3004, 2'd2, 1'b1, 32'hA1B2_C3D4, 2'b10, 3'd2, 32'hA1B2_C3D4, 1'b1);
   endtask

   task automatic t_faults();
      t_fault(32'h4000_4001, 2'd1, 1'b0);
      t_fault(32'h4000_4003, 2'd1, 1'b1);
      t_fault(32'h4000_4002, 2'd2, 1'b1);
      t_fault(32'h4000_4001, 2'd3, 1'b0);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      t_reset();
      t_byte_writes();
      t_half_word_writes();
      t_reads();
      t_faults();
      // back-to-back after faults: normal access still works
      t_write(32'h4000_5003, 2'd0, 32'h0000_00EE, 1'b0, 3'd0, 4'b1000, 32'hEE00_0000, 2'b00, 1'b0);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

endmodule